// File: doc/BRIEF.md
# SHA-256 Block Hash Engine

This engine computes the SHA-256 digest of a message that has already been padded outside it into a whole number of 512-bit blocks. The engine takes one complete block at a time from a wide input bus when the load strobe is high. It then runs the compression function iteratively, one round per clock, and folds the result into a 256-bit chaining value that it keeps between blocks.

The caller sends each block of a message in turn, waiting while the busy flag is high. After the last block, the caller pulses the finalize strobe. The chaining value is then copied to the registered digest output and the valid flag rises. At the same moment the chaining value returns to the SHA-256 initial words, so the next message can start at once. Padding, length counting and other digest sizes are left to the caller.

Top module: `sha256_core`

## Requirements
- R1: Reset clears busy_o, valid_o and digest_o to zero and sets the chaining value to the eight SHA-256 initial words.
- R2: Message word j (0..15) of a block is block_i[511-32*j -: 32], with the first message byte in bits 511:504. Digest word i (0..7) is digest_o[255-32*i -: 32].
- R3: A load is accepted on a clock edge where the engine is idle, load_i is high and final_i is low. busy_o is high for exactly 65 cycles after that edge, so a new block can be sent every 66 cycles.
- R4: load_i has no effect while busy_o is high. The block in progress runs to completion and its result is unchanged.
- R5: final_i has no effect while busy_o is high. digest_o, valid_o and the block result are unchanged.
- R6: A finalize accepted while idle sets valid_o and places the chaining value (the SHA-256 of the blocks loaded since reset or since the previous finalize) on digest_o on the next cycle. It also restores the chaining value to the initial words.
- R7: When load_i and final_i are both high on an idle edge, the finalize is taken and the load is dropped. busy_o stays low.
- R8: An accepted load clears valid_o on the next cycle. digest_o keeps its value until the next accepted finalize.
- R9: A finalize with no block loaded since the last reset or finalize outputs the eight initial words.
- R10: Blocks chain: the second and later blocks of a message start from the chaining value left by the block before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Strobe: take block_i as the next message block |
| final_i | input | 1 | Strobe: end of message, publish the digest |
| block_i | input | 512 | One padded message block, word 0 in the top bits |
| busy_o | output | 1 | A block is being compressed; strobes are ignored |
| valid_o | output | 1 | digest_o holds the digest of a completed message |
| digest_o | output | 256 | Registered digest, word 0 in the top bits |

## Verification
A wrong round constant, wrong schedule tap or wrong working-variable rotation stays hidden inside the engine until a finalize. It then shows up as a digest that differs in most of its bits, so each message's digest is checked one cycle after its finalize. A fault in the control counter shows up sooner: busy_o stays high for more or fewer than 65 cycles after the load. A fault in the chaining update, or in how stray strobes are handled, only shows in the digest of a multi-block message, or in a digest that should have stayed fixed while busy. The stimulus therefore includes such messages and such strobes.

// File: rtl/sha256_pkg.sv
package sha256_pkg;
  localparam int WORD_W   = 32;
  localparam int WIN_N    = 16;
  localparam int STATE_N  = 8;
  localparam int ROUNDS_N = 64;
  localparam int BLOCK_W  = WORD_W * WIN_N;
  localparam int DIGEST_W = WORD_W * STATE_N;
  localparam int RND_W    = $clog2(ROUNDS_N);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [0:STATE_N-1][WORD_W-1:0] state_t;
  typedef logic [0:WIN_N-1][WORD_W-1:0] block_t;
  typedef enum logic [1:0] {PH_IDLE, PH_ROUND, PH_FOLD} phase_e;

  localparam state_t INIT_WORDS = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  localparam logic [0:ROUNDS_N-1][WORD_W-1:0] ROUND_K = {
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  function automatic word_t rotr(word_t x, int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t small_s0(word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t small_s1(word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t choose(word_t e, word_t f, word_t g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic word_t majority(word_t a, word_t b, word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction
endpackage

// File: rtl/sha256_sched.sv
module sha256_sched
  import sha256_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_en,
  input  logic   shift_en,
  input  block_t blk_i,
  output word_t  w_o
);
  word_t win_q [WIN_N];
  word_t w_next;

  assign w_next = small_s1(win_q[14]) + win_q[9] + small_s0(win_q[1]) + win_q[0];
  assign w_o    = win_q[0];

  for (genvar i = 0; i < WIN_N; i++) begin : g_win
    if (i == WIN_N - 1) begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        win_q[i] <= '0;
        else if (load_en)  win_q[i] <= blk_i[i];
        else if (shift_en) win_q[i] <= w_next;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        win_q[i] <= '0;
        else if (load_en)  win_q[i] <= blk_i[i];
        else if (shift_en) win_q[i] <= win_q[i+1];
      end
    end
  end

  // R2: the first round consumes message word 0 of the captured block
  assert_first_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> w_o == $past(blk_i[0]));
endmodule

// File: rtl/sha256_round.sv
module sha256_round
  import sha256_pkg::*;
(
  input  state_t st_i,
  input  word_t  k_i,
  input  word_t  w_i,
  output state_t st_o
);
  word_t t1, t2;

  assign t1 = st_i[7] + big_s1(st_i[4]) + choose(st_i[4], st_i[5], st_i[6]) + k_i + w_i;
  assign t2 = big_s0(st_i[0]) + majority(st_i[0], st_i[1], st_i[2]);

  always_comb begin
    st_o    = st_i;
    st_o[0] = t1 + t2;
    st_o[1] = st_i[0];
    st_o[2] = st_i[1];
    st_o[3] = st_i[2];
    st_o[4] = st_i[3] + t1;
    st_o[5] = st_i[4];
    st_o[6] = st_i[5];
    st_o[7] = st_i[6];
  end
endmodule

// File: rtl/sha256_ctrl.sv
module sha256_ctrl
  import sha256_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             final_i,
  output logic             load_acc,
  output logic             final_acc,
  output logic             round_en,
  output logic             fold_en,
  output logic [RND_W-1:0] rnd_o,
  output logic             busy_o
);
  phase_e phase_q;
  logic [RND_W-1:0] rnd_q;
  logic rnd_last;

  assign rnd_last  = (rnd_q == RND_W'(ROUNDS_N - 1));
  assign busy_o    = (phase_q != PH_IDLE);
  assign final_acc = !busy_o && final_i;
  assign load_acc  = !busy_o && load_i && !final_i;
  assign round_en  = (phase_q == PH_ROUND);
  assign fold_en   = (phase_q == PH_FOLD);
  assign rnd_o     = rnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      rnd_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (load_acc) begin
          phase_q <= PH_ROUND;
          rnd_q   <= '0;
        end
        PH_ROUND: begin
          rnd_q <= rnd_q + 1'b1;
          if (rnd_last) phase_q <= PH_FOLD;
        end
        PH_FOLD: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assert_load_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_acc |=> busy_o && round_en && rnd_o == '0);
  assert_fold_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fold_en |=> !busy_o);
  assert_rounds_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (round_en && rnd_o != RND_W'(ROUNDS_N - 1)) |=> round_en && rnd_o == RND_W'($past(rnd_o) + 1'b1));
  assert_final_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && load_i && final_i) |=> !busy_o);
endmodule

// File: rtl/sha256_core.sv
module sha256_core
  import sha256_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                final_i,
  input  logic [BLOCK_W-1:0]  block_i,
  output logic                busy_o,
  output logic                valid_o,
  output logic [DIGEST_W-1:0] digest_o
);
  logic load_acc, final_acc, round_en, fold_en;
  logic [RND_W-1:0] rnd;
  word_t  w_cur;
  state_t chain_q, work_q, work_nxt, chain_sum, dig_q;
  logic   valid_q;

  sha256_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .final_i(final_i),
    .load_acc(load_acc), .final_acc(final_acc), .round_en(round_en),
    .fold_en(fold_en), .rnd_o(rnd), .busy_o(busy_o)
  );

  sha256_sched u_sched (
    .clk(clk), .rst_n(rst_n), .load_en(load_acc), .shift_en(round_en),
    .blk_i(block_t'(block_i)), .w_o(w_cur)
  );

  sha256_round u_round (
    .st_i(work_q), .k_i(ROUND_K[rnd]), .w_i(w_cur), .st_o(work_nxt)
  );

  for (genvar i = 0; i < STATE_N; i++) begin : g_fold
    assign chain_sum[i] = chain_q[i] + work_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= INIT_WORDS;
      work_q  <= '0;
      dig_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (load_acc)      work_q <= chain_q;
      else if (round_en) work_q <= work_nxt;

      if (final_acc)    chain_q <= INIT_WORDS;
      else if (fold_en) chain_q <= chain_sum;

      if (final_acc) begin
        dig_q   <= chain_q;
        valid_q <= 1'b1;
      end else if (load_acc) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign digest_o = dig_q;
  assign valid_o  = valid_q;

  assert_publish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    final_acc |=> valid_o && digest_o == DIGEST_W'($past(chain_q)));
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    final_acc |=> chain_q == INIT_WORDS);
  assert_load_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_acc |=> !valid_o);
  assert_digest_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !final_acc |=> $stable(digest_o));
  assert_busy_final_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && final_i) |=> $stable(valid_o));
endmodule

// File: tb/sha256_core_bench.sv
`timescale 1ns/1ps
module sha256_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0;
  logic final_i = 1'b0;
  logic [511:0] block_i = '0;
  logic busy_o, valid_o;
  logic [255:0] digest_o;

  int checks = 0;
  int fails = 0;
  logic [31:0] kt [64];
  logic [255:0] ivt;
  logic [255:0] model_h;

  always #2.5 clk = ~clk;

  sha256_core u_sha256_core (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .final_i(final_i),
    .block_i(block_i), .busy_o(busy_o), .valid_o(valid_o), .digest_o(digest_o)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  function automatic logic [255:0] compress(input logic [255:0] h, input logic [511:0] blk);
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] x, y;
    for (int t = 0; t < 16; t++) w[t] = blk[511 - 32*t -: 32];
    for (int t = 16; t < 64; t++)
      w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
           + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
    for (int i = 0; i < 8; i++) v[i] = h[255 - 32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      x = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
        + ((v[4] & v[5]) | (~v[4] & v[6])) + kt[t] + w[t];
      y = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
        + ((v[0] & v[1]) | (v[2] & (v[0] | v[1])));
      for (int i = 7; i > 0; i--) v[i] = v[i-1];
      v[4] = v[4] + x;
      v[0] = x + y;
    end
    for (int i = 0; i < 8; i++) compress[255 - 32*i -: 32] = h[255 - 32*i -: 32] + v[i];
  endfunction

  function automatic logic [31:0] frac32(input real r);
    real f;
    f = r - $floor(r);
    return 32'(longint'($floor(f * 4294967296.0)));
  endfunction

  task automatic build_constants();
    int p = 2;
    for (int n = 0; n < 64; n++) begin
      bit prime;
      real c;
      do begin
        prime = 1'b1;
        for (int d = 2; d * d <= p; d++) if (p % d == 0) prime = 1'b0;
        if (!prime) p++;
      end while (!prime);
      c = $pow(real'(p), 1.0 / 3.0);
      c = c - (c * c * c - real'(p)) / (3.0 * c * c);
      kt[n] = frac32(c);
      if (n < 8) ivt[255 - 32*n -: 32] = frac32($sqrt(real'(p)));
      p++;
    end
  endtask

  // Loads one block, models it, measures busy length; inj adds stray strobes mid-block.
  task automatic send_block(input logic [511:0] blk, input bit inj);
    int n;
    logic [255:0] d_hold;
    logic v_hold;
    logic [255:0] d_before;
    while (busy_o) @(negedge clk);
    d_before = digest_o;
    block_i = blk;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    model_h = compress(model_h, blk);
    chk(!valid_o, "R8 valid cleared by load", {255'd0, valid_o}, 256'd0);
    chk(digest_o == d_before, "R8 digest held after load", digest_o, d_before);
    n = 0;
    d_hold = '0;
    v_hold = 1'b0;
    while (busy_o) begin
      n++;
      if (inj && n == 21)
        chk(digest_o == d_hold && valid_o == v_hold, "R5 final while busy ignored", digest_o, d_hold);
      load_i = inj && (n == 10);
      final_i = inj && (n == 20);
      if (inj && n == 10) block_i = {$urandom, $urandom, $urandom, $urandom, 384'h0};
      if (inj && n == 20) begin
        d_hold = digest_o;
        v_hold = valid_o;
      end
      @(negedge clk);
    end
    load_i = 1'b0;
    final_i = 1'b0;
    chk(n == 65, "R3 busy length", 256'(n), 256'd65);
  endtask

  task automatic finish_msg(input string req);
    final_i = 1'b1;
    @(negedge clk);
    final_i = 1'b0;
    chk(valid_o, {req, " valid after finalize"}, {255'd0, valid_o}, 256'd1);
    chk(digest_o == model_h, {req, " digest"}, digest_o, model_h);
    model_h = ivt;
  endtask

  initial begin
    logic [511:0] b1, b2;
    logic [255:0] kat;
    build_constants();
    model_h = ivt;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && valid_o == 1'b0 && digest_o == '0, "R1 reset state",
        {busy_o, valid_o, digest_o[253:0]}, 256'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: empty finalize yields initial words (checks bench constants too)
    finish_msg("R9 no-block");
    chk(digest_o == 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19,
        "R9 initial words", digest_o, 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19);

    // R2 R6: empty message
    send_block({8'h80, 440'h0, 64'd0}, 1'b0);
    finish_msg("R6 empty");
    kat = 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;
    chk(digest_o == kat, "R2 empty known answer", digest_o, kat);

    // R2: three-byte message
    send_block({"abc", 8'h80, 416'h0, 64'd24}, 1'b0);
    finish_msg("R6 abc");
    kat = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
    chk(digest_o == kat, "R2 abc known answer", digest_o, kat);

    // R10 with stray strobes (R4, R5)
    b1 = {"abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq", 8'h80, 56'h0};
    b2 = {448'h0, 64'd448};
    send_block(b1, 1'b1);
    send_block(b2, 1'b1);
    finish_msg("R4 two-block");
    kat = 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;
    chk(digest_o == kat, "R10 two-block known answer", digest_o, kat);

    // R7: simultaneous strobes, finalize wins
    void'($urandom(32'd4242));
    b1 = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
          $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    b2 = ~b1;
    send_block(b1, 1'b0);
    block_i = b2;
    load_i = 1'b1;
    final_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    final_i = 1'b0;
    chk(!busy_o, "R7 load dropped", {255'd0, busy_o}, 256'd0);
    chk(valid_o && digest_o == model_h, "R7 finalize taken", digest_o, model_h);
    model_h = ivt;
    send_block(b2, 1'b0);
    finish_msg("R7 fresh message");

    // Random messages of 1..3 blocks
    for (int m = 0; m < 5; m++) begin
      int nb = 1 + ($urandom % 3);
      for (int b = 0; b < nb; b++) begin
        for (int j = 0; j < 16; j++) b1[511 - 32*j -: 32] = $urandom;
        send_block(b1, (m % 2) == 1);
      end
      finish_msg("R10 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule